// File: doc/BRIEF.md
# Segmented Virtual Address Translator

This block turns a 32-bit virtual address from a RISC core into a physical address in the same cycle. Alongside the physical address it returns a read permission, a write permission and a signed three-bit result code. A segment decoder looks at the top address bits first. Two kernel windows in the upper half of the space are mapped by subtracting a fixed base, and they never touch the translation buffer. An error-level override sends the lower half of the space through unchanged. Every other address is looked up in a small fully associative translation buffer.

Each buffer entry holds one virtual tag, which covers an even/odd pair of 4 KB pages. It also holds an 8-bit space identifier and a global flag. Each of the two pages in the pair has its own frame number, valid flag and dirty flag. Entries are loaded through a clocked write port. The lookup itself is purely combinational. Choosing which entry to replace and walking page tables belong to the surrounding logic.

Top module: `seg_xlat`

## Requirements
- R1: When `user_mode` is 1 and `va[31]` is 1, `result` is -1 (3'b111, bad address). On this code, and on every non-zero code, `pa` is 0 and both permissions are 0.
- R2: When `va[31]` is 0 and `err_level` is 1, `pa` equals `va` and both permissions are 1. `result` is 0 (match), whatever the buffer holds.
- R3: Addresses 0x80000000..0x9FFFFFFF give `pa = va - 0x80000000`. Addresses 0xA0000000..0xBFFFFFFF give `pa = va - 0xA0000000`. Both windows give read and write permission and `result` 0, independent of the buffer.
- R4: Addresses below 0x80000000 with `err_level` 0, and addresses from 0xC0000000 upward, are looked up in the buffer. If no entry hits, `result` is -2 (3'b110). The other codes are 0 match, -1 bad address, -3 invalid (3'b101) and -4 modified (3'b100).
- R5: An entry hits when its stored tag equals `va[31:13]` and either its global flag is 1 or its identifier equals `cur_asid`.
- R6: `va[12]` picks the half of the hitting entry: 0 selects the even frame, valid and dirty fields, and 1 selects the odd ones.
- R7: A hit whose selected valid flag is 0 gives `result` -3.
- R8: A valid hit with `is_write` 1 and the selected dirty flag 0 gives `result` -4. The same hit with `is_write` 0 gives match, with `perm_wr` 0.
- R9: On a match through the buffer, `pa` is `{frame, va[11:0]}` and `perm_rd` is 1. `perm_wr` equals the selected dirty flag.
- R10: When several entries hit, the one with the lowest index decides the outcome.
- R11: When `wr_en` is 1, the entry `wr_idx` takes all write-port fields at the rising clock edge. An active-low `rst_n` clears every field of every entry to 0, so an all-zero entry then hits identifier 0 at tag 0 and reports invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the buffer write port |
| rst_n | input | 1 | Asynchronous active-low reset of the buffer |
| va | input | 32 | Virtual address |
| is_write | input | 1 | 1 for a store access |
| user_mode | input | 1 | 1 when the core runs unprivileged |
| err_level | input | 1 | Error-level override for the lower half |
| cur_asid | input | 8 | Current address space identifier |
| pa | output | 32 | Physical address, 0 on any fault |
| perm_rd | output | 1 | Read permitted |
| perm_wr | output | 1 | Write permitted |
| result | output | 3 | Signed result code |
| wr_en | input | 1 | Buffer write strobe |
| wr_idx | input | 4 | Entry to write |
| wr_vpn2 | input | 19 | Tag for the page pair |
| wr_asid | input | 8 | Identifier of the entry |
| wr_global | input | 1 | Global flag of the entry |
| wr_pfn_even | input | 20 | Frame number of the even page |
| wr_valid_even | input | 1 | Valid flag of the even page |
| wr_dirty_even | input | 1 | Dirty flag of the even page |
| wr_pfn_odd | input | 20 | Frame number of the odd page |
| wr_valid_odd | input | 1 | Valid flag of the odd page |
| wr_dirty_odd | input | 1 | Dirty flag of the odd page |

## Verification
The bench builds the block with its defaults: 32-bit addresses, 4 KB pages, 16 entries and 8-bit identifiers. With these values the fixed window boundaries fall on exact constants that the reference model can compute directly. Sixteen entries also leave room to load deliberately overlapping tags, at low and high indices, with global and private identifiers, which is what exercises the lowest-index rule. The 12-bit page offset puts the half select at bit 12, so a single address step moves a lookup between the even and odd pages of one entry.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   typedef enum logic [2:0] {
      SEG_BAD,
      SEG_PASS,
      SEG_WIN_A,
      SEG_WIN_B,
      SEG_MAPPED
   } seg_kind_e;

   localparam logic [2:0] RES_MATCH    = 3'b000;
   localparam logic [2:0] RES_BADADDR  = 3'b111;
   localparam logic [2:0] RES_NOMATCH  = 3'b110;
   localparam logic [2:0] RES_INVALID  = 3'b101;
   localparam logic [2:0] RES_MODIFIED = 3'b100;

endpackage

// File: rtl/xlat_seg_decode.sv
module xlat_seg_decode
   import xlat_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] va,
   input  logic              user_mode,
   input  logic              err_level,
   output seg_kind_e         kind,
   output logic [ADDR_W-1:0] win_pa
);
   localparam logic [ADDR_W-1:0] BASE_A = {3'b100, {(ADDR_W-3){1'b0}}};
   localparam logic [ADDR_W-1:0] BASE_B = {3'b101, {(ADDR_W-3){1'b0}}};

   logic [2:0] top3;
   assign top3 = va[ADDR_W-1 -: 3];

   always_comb begin
      win_pa = '0;
      if (user_mode && top3[2]) begin
         kind = SEG_BAD;
      end else if (!top3[2]) begin
         kind   = err_level ? SEG_PASS : SEG_MAPPED;
         win_pa = va;
      end else if (top3 == 3'b100) begin
         kind   = SEG_WIN_A;
         win_pa = va - BASE_A;
      end else if (top3 == 3'b101) begin
         kind   = SEG_WIN_B;
         win_pa = va - BASE_B;
      end else begin
         kind = SEG_MAPPED;
      end
   end
endmodule

// File: rtl/xlat_tlb_store.sv
module xlat_tlb_store #(
   parameter int ENTRIES = 16,
   parameter int VPN2_W  = 19,
   parameter int ASID_W  = 8,
   parameter int PFN_W   = 20,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [IDX_W-1:0]               wr_idx,
   input  logic [VPN2_W-1:0]              wr_vpn2,
   input  logic [ASID_W-1:0]              wr_asid,
   input  logic                           wr_global,
   input  logic [PFN_W-1:0]               wr_pfn_even,
   input  logic                           wr_valid_even,
   input  logic                           wr_dirty_even,
   input  logic [PFN_W-1:0]               wr_pfn_odd,
   input  logic                           wr_valid_odd,
   input  logic                           wr_dirty_odd,
   output logic [ENTRIES-1:0][VPN2_W-1:0] ent_vpn2,
   output logic [ENTRIES-1:0][ASID_W-1:0] ent_asid,
   output logic [ENTRIES-1:0]             ent_global,
   output logic [ENTRIES-1:0][1:0][PFN_W-1:0] ent_pfn,
   output logic [ENTRIES-1:0][1:0]        ent_valid,
   output logic [ENTRIES-1:0][1:0]        ent_dirty
);
   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
      logic sel_w;
      assign sel_w = wr_en && (wr_idx == MY_IDX);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_vpn2[i]   <= '0;
            ent_asid[i]   <= '0;
            ent_global[i] <= 1'b0;
            ent_pfn[i]    <= '0;
            ent_valid[i]  <= '0;
            ent_dirty[i]  <= '0;
         end else if (sel_w) begin
            ent_vpn2[i]   <= wr_vpn2;
            ent_asid[i]   <= wr_asid;
            ent_global[i] <= wr_global;
            ent_pfn[i]    <= {wr_pfn_odd, wr_pfn_even};
            ent_valid[i]  <= {wr_valid_odd, wr_valid_even};
            ent_dirty[i]  <= {wr_dirty_odd, wr_dirty_even};
         end
      end
   end

   assert_entry_loaded_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (ent_vpn2[$past(wr_idx)] == $past(wr_vpn2)) &&
                (ent_pfn[$past(wr_idx)][0] == $past(wr_pfn_even)) &&
                (ent_valid[$past(wr_idx)][1] == $past(wr_valid_odd)));
endmodule

// File: rtl/xlat_tlb_match.sv
module xlat_tlb_match #(
   parameter int ENTRIES = 16,
   parameter int VPN2_W  = 19,
   parameter int ASID_W  = 8,
   parameter int PFN_W   = 20
) (
   input  logic [ENTRIES-1:0][VPN2_W-1:0]     ent_vpn2,
   input  logic [ENTRIES-1:0][ASID_W-1:0]     ent_asid,
   input  logic [ENTRIES-1:0]                 ent_global,
   input  logic [ENTRIES-1:0][1:0][PFN_W-1:0] ent_pfn,
   input  logic [ENTRIES-1:0][1:0]            ent_valid,
   input  logic [ENTRIES-1:0][1:0]            ent_dirty,
   input  logic [VPN2_W-1:0]                  look_vpn2,
   input  logic                               look_odd,
   input  logic [ASID_W-1:0]                  look_asid,
   output logic                               hit,
   output logic [PFN_W-1:0]                   hit_pfn,
   output logic                               hit_valid,
   output logic                               hit_dirty
);
   logic [ENTRIES-1:0] hit_vec;
   logic [ENTRIES-1:0] first_vec;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      assign hit_vec[i] = (ent_vpn2[i] == look_vpn2) &&
                          (ent_global[i] || (ent_asid[i] == look_asid));
   end

   // isolate the lowest set bit: lowest index has priority
   assign first_vec = hit_vec & (~hit_vec + ENTRIES'(1));
   assign hit       = |hit_vec;

   always_comb begin
      hit_pfn   = '0;
      hit_valid = 1'b0;
      hit_dirty = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (first_vec[i]) begin
            hit_pfn   = hit_pfn   | ent_pfn[i][look_odd];
            hit_valid = hit_valid | ent_valid[i][look_odd];
            hit_dirty = hit_dirty | ent_dirty[i][look_odd];
         end
      end
   end
endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
   import xlat_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int PAGE_BITS = 12,
   parameter int ENTRIES   = 16,
   parameter int ASID_W    = 8,
   localparam int VPN2_W   = ADDR_W - PAGE_BITS - 1,
   localparam int PFN_W    = ADDR_W - PAGE_BITS,
   localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] va,
   input  logic              is_write,
   input  logic              user_mode,
   input  logic              err_level,
   input  logic [ASID_W-1:0] cur_asid,
   output logic [ADDR_W-1:0] pa,
   output logic              perm_rd,
   output logic              perm_wr,
   output logic [2:0]        result,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [VPN2_W-1:0] wr_vpn2,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic              wr_global,
   input  logic [PFN_W-1:0]  wr_pfn_even,
   input  logic              wr_valid_even,
   input  logic              wr_dirty_even,
   input  logic [PFN_W-1:0]  wr_pfn_odd,
   input  logic              wr_valid_odd,
   input  logic              wr_dirty_odd
);
   if (ADDR_W != 32) begin : g_chk_aw
      $error("seg_xlat: segment map assumes a 32-bit address");
   end
   if (PAGE_BITS < 10 || PAGE_BITS > ADDR_W - 4) begin : g_chk_pg
      $error("seg_xlat: page size out of range");
   end
   if (ENTRIES < 1 || ENTRIES > 256) begin : g_chk_ent
      $error("seg_xlat: entry count out of range");
   end
   if (ASID_W < 1) begin : g_chk_asid
      $error("seg_xlat: identifier width must be positive");
   end

   seg_kind_e         kind;
   logic [ADDR_W-1:0] win_pa;

   logic [ENTRIES-1:0][VPN2_W-1:0]     ent_vpn2;
   logic [ENTRIES-1:0][ASID_W-1:0]     ent_asid;
   logic [ENTRIES-1:0]                 ent_global;
   logic [ENTRIES-1:0][1:0][PFN_W-1:0] ent_pfn;
   logic [ENTRIES-1:0][1:0]            ent_valid;
   logic [ENTRIES-1:0][1:0]            ent_dirty;

   logic             hit;
   logic [PFN_W-1:0] hit_pfn;
   logic             hit_valid;
   logic             hit_dirty;

   xlat_seg_decode #(.ADDR_W(ADDR_W)) u_seg (
      .va        (va),
      .user_mode (user_mode),
      .err_level (err_level),
      .kind      (kind),
      .win_pa    (win_pa)
   );

   xlat_tlb_store #(
      .ENTRIES(ENTRIES), .VPN2_W(VPN2_W), .ASID_W(ASID_W), .PFN_W(PFN_W)
   ) u_store (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_en         (wr_en),
      .wr_idx        (wr_idx),
      .wr_vpn2       (wr_vpn2),
      .wr_asid       (wr_asid),
      .wr_global     (wr_global),
      .wr_pfn_even   (wr_pfn_even),
      .wr_valid_even (wr_valid_even),
      .wr_dirty_even (wr_dirty_even),
      .wr_pfn_odd    (wr_pfn_odd),
      .wr_valid_odd  (wr_valid_odd),
      .wr_dirty_odd  (wr_dirty_odd),
      .ent_vpn2      (ent_vpn2),
      .ent_asid      (ent_asid),
      .ent_global    (ent_global),
      .ent_pfn       (ent_pfn),
      .ent_valid     (ent_valid),
      .ent_dirty     (ent_dirty)
   );

   xlat_tlb_match #(
      .ENTRIES(ENTRIES), .VPN2_W(VPN2_W), .ASID_W(ASID_W), .PFN_W(PFN_W)
   ) u_match (
      .ent_vpn2   (ent_vpn2),
      .ent_asid   (ent_asid),
      .ent_global (ent_global),
      .ent_pfn    (ent_pfn),
      .ent_valid  (ent_valid),
      .ent_dirty  (ent_dirty),
      .look_vpn2  (va[ADDR_W-1 -: VPN2_W]),
      .look_odd   (va[PAGE_BITS]),
      .look_asid  (cur_asid),
      .hit        (hit),
      .hit_pfn    (hit_pfn),
      .hit_valid  (hit_valid),
      .hit_dirty  (hit_dirty)
   );

   always_comb begin
      pa      = '0;
      perm_rd = 1'b0;
      perm_wr = 1'b0;
      result  = RES_MATCH;
      unique case (kind)
         SEG_BAD: result = RES_BADADDR;
         SEG_PASS, SEG_WIN_A, SEG_WIN_B: begin
            pa      = win_pa;
            perm_rd = 1'b1;
            perm_wr = 1'b1;
         end
         default: begin
            if (!hit) begin
               result = RES_NOMATCH;
            end else if (!hit_valid) begin
               result = RES_INVALID;
            end else if (is_write && !hit_dirty) begin
               result = RES_MODIFIED;
            end else begin
               pa      = {hit_pfn, va[PAGE_BITS-1:0]};
               perm_rd = 1'b1;
               perm_wr = hit_dirty;
            end
         end
      endcase
   end

   assert_user_high_bad_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (user_mode && va[ADDR_W-1]) |-> (result == RES_BADADDR));

   assert_err_level_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (err_level && !va[ADDR_W-1]) |-> (pa == va && result == RES_MATCH && perm_wr));

   assert_kernel_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!user_mode && va[ADDR_W-1 -: 2] == 2'b10) |->
         (result == RES_MATCH && pa[ADDR_W-1 -: 3] == 3'b000 &&
          pa[ADDR_W-4:0] == va[ADDR_W-4:0]));

   assert_fault_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (result != RES_MATCH) |-> (pa == '0 && !perm_rd && !perm_wr));

   assert_write_needs_dirty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (result == RES_MATCH && is_write) |-> perm_wr);
endmodule

// File: tb/test_seg_xlat.sv
`timescale 1ns/1ps
module test_seg_xlat;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] va = '0;
   logic        is_write = 1'b0, user_mode = 1'b0, err_level = 1'b0;
   logic [7:0]  cur_asid = '0;
   logic [31:0] pa;
   logic        perm_rd, perm_wr;
   logic [2:0]  result;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic [18:0] wr_vpn2 = '0;
   logic [7:0]  wr_asid = '0;
   logic        wr_global = 1'b0;
   logic [19:0] wr_pfn_even = '0, wr_pfn_odd = '0;
   logic        wr_valid_even = 1'b0, wr_dirty_even = 1'b0;
   logic        wr_valid_odd = 1'b0, wr_dirty_odd = 1'b0;

   int n_cmp = 0, n_bad = 0;
   bit check_on = 1'b0;
   bit done = 1'b0;
   string phase = "R11";

   always #2 clk = ~clk;

   seg_xlat i_seg_xlat (
      .clk(clk), .rst_n(rst_n), .va(va), .is_write(is_write),
      .user_mode(user_mode), .err_level(err_level), .cur_asid(cur_asid),
      .pa(pa), .perm_rd(perm_rd), .perm_wr(perm_wr), .result(result),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn2(wr_vpn2), .wr_asid(wr_asid),
      .wr_global(wr_global), .wr_pfn_even(wr_pfn_even),
      .wr_valid_even(wr_valid_even), .wr_dirty_even(wr_dirty_even),
      .wr_pfn_odd(wr_pfn_odd), .wr_valid_odd(wr_valid_odd),
      .wr_dirty_odd(wr_dirty_odd)
   );

   // reference buffer contents
   int unsigned m_vpn[16];
   int          m_asid[16];
   bit          m_g[16];
   int unsigned m_pfn[16][2];
   bit          m_v[16][2];
   bit          m_d[16][2];

   task automatic model_clear();
      for (int i = 0; i < 16; i++) begin
         m_vpn[i] = 0; m_asid[i] = 0; m_g[i] = 0;
         for (int h = 0; h < 2; h++) begin
            m_pfn[i][h] = 0; m_v[i][h] = 0; m_d[i][h] = 0;
         end
      end
   endtask

   task automatic model(output int unsigned e_pa, output bit e_r, output bit e_w,
                        output int e_code, output string e_req);
      int unsigned a = va;
      int hit_i = -1;
      e_pa = 0; e_r = 0; e_w = 0; e_code = 0;
      if (user_mode && a >= 32'h8000_0000) begin
         e_code = -1; e_req = "R1";
      end else if (a < 32'h8000_0000 && err_level) begin
         e_pa = a; e_r = 1; e_w = 1; e_req = "R2";
      end else if (a >= 32'h8000_0000 && a < 32'hA000_0000) begin
         e_pa = a - 32'h8000_0000; e_r = 1; e_w = 1; e_req = "R3";
      end else if (a >= 32'hA000_0000 && a < 32'hC000_0000) begin
         e_pa = a - 32'hA000_0000; e_r = 1; e_w = 1; e_req = "R3";
      end else begin
         for (int i = 0; i < 16; i++) begin
            if (hit_i < 0 && m_vpn[i] == (a >> 13) &&
                (m_g[i] || m_asid[i] == int'(cur_asid)))
               hit_i = i;
         end
         if (hit_i < 0) begin
            e_code = -2; e_req = "R4";
         end else begin
            int h = (a >> 12) & 1;
            if (!m_v[hit_i][h]) begin
               e_code = -3; e_req = "R7";
            end else if (is_write && !m_d[hit_i][h]) begin
               e_code = -4; e_req = "R8";
            end else begin
               e_pa = (m_pfn[hit_i][h] << 12) | (a & 32'hFFF);
               e_r = 1; e_w = m_d[hit_i][h]; e_req = "R9";
            end
         end
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && check_on && !done) begin
         int unsigned e_pa; bit e_r, e_w; int e_code; string e_req;
         model(e_pa, e_r, e_w, e_code, e_req);
         n_cmp++;
         if (pa !== e_pa || perm_rd !== e_r || perm_wr !== e_w ||
             int'($signed(result)) != e_code) begin
            n_bad++;
            $display("FAIL %s/%s va=%h: got pa=%h r=%0b w=%0b code=%0d, expected pa=%h r=%0b w=%0b code=%0d",
                     e_req, phase, va, pa, perm_rd, perm_wr, int'($signed(result)),
                     e_pa, e_r, e_w, e_code);
         end
      end
   end

   task automatic look(input logic [31:0] a, input bit w, input bit u, input bit e,
                       input logic [7:0] id);
      @(posedge clk); #1;
      va = a; is_write = w; user_mode = u; err_level = e; cur_asid = id;
   endtask

   task automatic load(input int idx, input int unsigned vpn2, input int id, input bit g,
                       input int unsigned pe, input bit ve, input bit de,
                       input int unsigned po, input bit vo, input bit dd);
      @(posedge clk); #1;
      wr_en = 1; wr_idx = 4'(idx); wr_vpn2 = 19'(vpn2); wr_asid = 8'(id); wr_global = g;
      wr_pfn_even = 20'(pe); wr_valid_even = ve; wr_dirty_even = de;
      wr_pfn_odd = 20'(po); wr_valid_odd = vo; wr_dirty_odd = dd;
      @(posedge clk); #1;
      wr_en = 0;
      m_vpn[idx] = vpn2; m_asid[idx] = id; m_g[idx] = g;
      m_pfn[idx][0] = pe; m_v[idx][0] = ve; m_d[idx][0] = de;
      m_pfn[idx][1] = po; m_v[idx][1] = vo; m_d[idx][1] = dd;
   endtask

   initial begin
      #150000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      model_clear();
      repeat (3) @(posedge clk);
      #1 rst_n = 1; check_on = 1;
      // R11: reset leaves all-zero entries: tag 0 / identifier 0 hits as invalid
      phase = "R11";
      look(32'h0000_1000, 0, 0, 0, 8'h00);
      look(32'h0040_0000, 0, 0, 0, 8'h00);
      // R1 user access to upper half, R4 user in lower half goes to buffer
      phase = "R1";
      look(32'h8000_0000, 0, 1, 0, 8'h00);
      look(32'hC000_0000, 1, 1, 0, 8'h00);
      look(32'hFFFF_FFFF, 0, 1, 1, 8'h00);
      look(32'h7FFF_F000, 0, 1, 0, 8'h00);
      // R2 error-level override
      phase = "R2";
      look(32'h1234_5678, 1, 0, 1, 8'h00);
      look(32'h0000_1000, 1, 1, 1, 8'h00);
      look(32'h8000_1234, 0, 0, 1, 8'h00);
      // R3 fixed windows and their edges
      phase = "R3";
      look(32'h9FFF_FFFC, 1, 0, 0, 8'h00);
      look(32'hA000_0010, 0, 0, 0, 8'h00);
      look(32'hBFFF_FFFF, 1, 0, 0, 8'h00);
      look(32'hC000_0000, 0, 0, 0, 8'h00);
      // R5/R6/R8/R9 private entry with even dirty, odd clean
      phase = "R9";
      load(3, 32'h0040_0000 >> 13, 5, 0, 20'h12345, 1, 1, 20'h54321, 1, 0);
      look(32'h0040_0ABC, 0, 0, 0, 8'h05);
      look(32'h0040_0ABC, 1, 0, 0, 8'h05);
      phase = "R6";
      look(32'h0040_1ABC, 0, 0, 0, 8'h05);
      phase = "R8";
      look(32'h0040_1ABC, 1, 0, 0, 8'h05);
      phase = "R5";
      look(32'h0040_0ABC, 0, 0, 0, 8'h06);
      look(32'h0040_2ABC, 0, 0, 0, 8'h05);
      // R7 global entry in the top quarter, even half invalid
      phase = "R7";
      load(7, 32'hC000_2000 >> 13, 9, 1, 20'h00001, 0, 1, 20'hFFFFF, 1, 1);
      look(32'hC000_2004, 0, 0, 0, 8'h33);
      look(32'hC000_3FFC, 1, 0, 0, 8'h77);
      look(32'hC000_3FFC, 1, 1, 0, 8'h77);
      // R10 overlapping tags
      phase = "R10";
      load(9, 32'h0080_0000 >> 13, 0, 1, 20'hAAAAA, 1, 1, 20'hAAAAB, 1, 1);
      load(2, 32'h0080_0000 >> 13, 1, 0, 20'hBBBBB, 1, 0, 20'hBBBBC, 0, 0);
      look(32'h0080_0010, 0, 0, 0, 8'h01);
      look(32'h0080_0010, 1, 0, 0, 8'h01);
      look(32'h0080_1010, 0, 0, 0, 8'h01);
      look(32'h0080_0010, 1, 0, 0, 8'h02);
      load(12, 32'hE000_0000 >> 13, 4, 1, 20'h0C0C0, 1, 0, 20'h0D0D0, 1, 1);
      load(13, 32'hE000_0000 >> 13, 4, 1, 20'h0E0E0, 1, 1, 20'h0F0F0, 1, 1);
      look(32'hE000_0FFF, 1, 0, 0, 8'h04);
      look(32'hE000_1FFF, 1, 0, 0, 8'h04);
      // R11 rewrite of an entry replaces it
      phase = "R11";
      load(3, 32'h0040_0000 >> 13, 5, 0, 20'h12345, 0, 1, 20'h54321, 1, 1);
      look(32'h0040_0ABC, 0, 0, 0, 8'h05);
      look(32'h0040_1ABC, 1, 0, 0, 8'h05);
      // sweep across segments and identifiers
      phase = "R4";
      for (int k = 0; k < 64; k++) begin
         look(32'(k) * 32'h0400_0000 + 32'h0040_0ABC + 32'(k % 3) * 32'h1000,
              bit'(k & 1), bit'((k >> 2) & 1), bit'((k >> 3) == 1), 8'(k % 6));
      end
      // R11 reset mid-run clears the whole buffer
      phase = "R11";
      @(posedge clk); #1;
      rst_n = 0; model_clear();
      @(posedge clk); #1;
      rst_n = 1;
      look(32'h0080_0010, 0, 0, 0, 8'h01);
      look(32'hC000_3FFC, 0, 0, 0, 8'h77);
      look(32'h0000_0FFC, 0, 0, 0, 8'h00);
      @(posedge clk); @(negedge clk); #1;
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule